// File: doc/BRIEF.md
# Two-Port Shared Memory Arbiter

This block decides which of two requesters owns a single shared memory. Each requester raises its request line while it wants the memory and lowers it to signal that it has finished. The arbiter keeps a two-valued owner state: the first port by default, the second when it has been granted. It drives a registered select line that steers the memory's address, data and control multiplexers toward the owner, along with one grant flag per port.

The second port wins when both ports ask in the same cycle. It cannot take the memory away from a first-port transfer that is already under way. A request from the first port counts as new in the cycle its line goes from low to high. That change is found by comparing the line with a copy of it registered on the previous clock. All inputs are synchronous to the single clock. The memory itself and the multiplexers are outside this block.

Top module: `mem_arb2`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `mem_sel` is 0, `p1_gnt` is 1 and `p2_gnt` is 0. Reset clears the registered copy of `p1_req` to 0.
- R2: When port 1 owns the memory, `p2_req` is 1 and `p1_req` is 0, ownership passes to port 2 at the next clock edge.
- R3: When port 1 owns the memory, `p2_req` is 1 and `p1_req` rises in the same cycle (1 now, 0 on the previous clock or since reset), ownership passes to port 2.
- R4: When port 1 owns the memory and `p1_req` is held (1 now and 1 on the previous clock), ownership stays with port 1 whatever `p2_req` does.
- R5: When port 2 owns the memory and `p2_req` is 0, ownership returns to port 1 at the next clock edge.
- R6: When port 2 owns the memory and `p2_req` is 1, ownership stays with port 2 whatever `p1_req` does.
- R7: When port 1 owns the memory and `p2_req` is 0, ownership stays with port 1.
- R8: The outputs encode ownership as follows. `mem_sel` is 0 for port 1 and 1 for port 2. `p1_gnt` equals the inverse of `mem_sel` and `p2_gnt` equals `mem_sel`, so exactly one grant is high.
- R9: All outputs are registered. A change in the requests shows on the outputs only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| p1_req | input | 1 | Port 1 request; high while service is wanted |
| p2_req | input | 1 | Port 2 request; high while service is wanted |
| mem_sel | output | 1 | Memory steering select: 0 port 1, 1 port 2 |
| p1_gnt | output | 1 | Port 1 owns the memory |
| p2_gnt | output | 1 | Port 2 owns the memory |

## Verification
Every result is due one rising edge after the request values it depends on. Both the owner state and the registered copy of `p1_req` load on that edge. The bench changes the requests on the falling edge and waits for the next rising edge. It samples the outputs one time unit later, well before the following falling edge. It sweeps every three-step sequence of the four request combinations, starting each sequence from reset. This covers a first request straight after reset, held requests, simultaneous rises and releases.

// File: rtl/arb_pkg.sv
package arb_pkg;

    typedef enum logic [0:0] {
        OWN_P1 = 1'b0,
        OWN_P2 = 1'b1
    } owner_e;

    typedef struct packed {
        logic p1;
        logic p2;
    } req_pair_t;

    localparam int unsigned NUM_PORTS = 2;

    function automatic logic is_rise(input logic now_v, input logic prev_v);
        return now_v & ~prev_v;
    endfunction

endpackage

// File: rtl/arb_edge_reg.sv
module arb_edge_reg #(
    parameter logic RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic sig_in,
    output logic sig_prev
);
    always_ff @(posedge clk) begin
        if (rst) sig_prev <= RESET_VAL;
        else     sig_prev <= sig_in;
    end

    // R9: the copy trails the input by exactly one clock
    p_copy_r9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (sig_prev == $past(sig_in)));
endmodule

// File: rtl/arb_grant_fsm.sv
module arb_grant_fsm
    import arb_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  req_pair_t req,
    input  logic      p1_prev,
    output owner_e    owner
);
    owner_e owner_nxt;
    logic   p1_new;

    assign p1_new = is_rise(req.p1, p1_prev);

    always_comb begin
        owner_nxt = owner;
        unique case (owner)
            OWN_P1: if (req.p2 && (!req.p1 || p1_new)) owner_nxt = OWN_P2;
            OWN_P2: if (!req.p2) owner_nxt = OWN_P1;
            default: owner_nxt = OWN_P1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) owner <= OWN_P1;
        else     owner <= owner_nxt;
    end

    p_idle_to_p2_r2: assert property (@(posedge clk) disable iff (rst)
        (owner == OWN_P1 && req.p2 && !req.p1) |=> (owner == OWN_P2));
    p_simul_p2_r3: assert property (@(posedge clk) disable iff (rst)
        (owner == OWN_P1 && req.p2 && req.p1 && !p1_prev) |=> (owner == OWN_P2));
    p_hold_p1_r4: assert property (@(posedge clk) disable iff (rst)
        (owner == OWN_P1 && req.p1 && p1_prev) |=> (owner == OWN_P1));
    p_release_r5: assert property (@(posedge clk) disable iff (rst)
        (owner == OWN_P2 && !req.p2) |=> (owner == OWN_P1));
    p_keep_p2_r6: assert property (@(posedge clk) disable iff (rst)
        (owner == OWN_P2 && req.p2) |=> (owner == OWN_P2));
    p_stay_p1_r7: assert property (@(posedge clk) disable iff (rst)
        (owner == OWN_P1 && !req.p2) |=> (owner == OWN_P1));
endmodule

// File: rtl/mem_arb2.sv
module mem_arb2
    import arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic p1_req,
    input  logic p2_req,
    output logic mem_sel,
    output logic p1_gnt,
    output logic p2_gnt
);
    req_pair_t req;
    logic      p1_prev;
    owner_e    owner;

    assign req.p1 = p1_req;
    assign req.p2 = p2_req;

    arb_edge_reg #(.RESET_VAL(1'b0)) u_edge (
        .clk      (clk),
        .rst      (rst),
        .sig_in   (p1_req),
        .sig_prev (p1_prev)
    );

    arb_grant_fsm u_fsm (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .p1_prev (p1_prev),
        .owner   (owner)
    );

    assign mem_sel = (owner == OWN_P2);
    assign p1_gnt  = (owner == OWN_P1);
    assign p2_gnt  = (owner == OWN_P2);

    p_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $countones({p1_gnt, p2_gnt}) == 1);
    p_sel_match_r8: assert property (@(posedge clk) disable iff (rst)
        p2_gnt == mem_sel);
    p_reset_owner_r1: assert property (@(posedge clk)
        $rose(rst) |=> (p1_gnt && !mem_sel));
endmodule

// File: tb/mem_arb2_tb.sv
module mem_arb2_tb;
    localparam time CLK_PERIOD = 10;
    localparam int  STEPS      = 3;
    localparam int  WATCHDOG   = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic p1_req = 1'b0;
    logic p2_req = 1'b0;
    logic mem_sel, p1_gnt, p2_gnt;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_arb2 u_dut (
        .clk     (clk),
        .rst     (rst),
        .p1_req  (p1_req),
        .p2_req  (p2_req),
        .mem_sel (mem_sel),
        .p1_gnt  (p1_gnt),
        .p2_gnt  (p2_gnt)
    );

    task automatic check_out(input logic exp_own, input string tag);
        n_checks++;
        if (mem_sel !== exp_own || p1_gnt !== ~exp_own || p2_gnt !== exp_own) begin
            n_fail++;
            $display("FAIL %s: sel/g1/g2 = %b%b%b expected %b%b%b", tag,
                     mem_sel, p1_gnt, p2_gnt, exp_own, ~exp_own, exp_own);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; p1_req = 1'b0; p2_req = 1'b0;
        @(posedge clk); #1;
        check_out(1'b0, "R1 during reset");
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: done=0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic  own, prev, a, b;
        string tag;
        repeat (2) @(posedge clk);
        for (int code = 0; code < 64; code++) begin
            do_reset();
            own  = 1'b0;
            prev = 1'b0; // R1: registered copy starts at 0
            for (int s = 0; s < STEPS; s++) begin
                a = code[2*s];
                b = code[2*s+1];
                p1_req = a; p2_req = b;
                if (own == 1'b0) begin
                    if (!b)              begin tag = "R7 p1 stays";        end
                    else if (!a)         begin tag = "R2 idle to p2"; own = 1'b1; end
                    else if (!prev)      begin tag = "R3 simultaneous";  own = 1'b1; end
                    else                 begin tag = "R4 p1 held";         end
                end else begin
                    if (!b)              begin tag = "R5 release to p1"; own = 1'b0; end
                    else                 begin tag = "R6 p2 keeps";        end
                end
                prev = a;
                // R9: outputs must not move before the edge
                #1;
                check_out(s == 0 ? 1'b0 : own_before(code, s), "R9 before edge");
                @(posedge clk); #1;
                check_out(own, tag);
                check_out(own, "R8 encoding");
                @(negedge clk);
            end
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    // Owner expected before step s of a sequence, recomputed from the rules
    function automatic logic own_before(input int code, input int s);
        logic o = 1'b0, p = 1'b0, x, y;
        for (int k = 0; k < s; k++) begin
            x = code[2*k]; y = code[2*k+1];
            if (!o) begin if (y && (!x || !p)) o = 1'b1; end
            else if (!y) o = 1'b0;
            p = x;
        end
        return o;
    endfunction
endmodule